// File: doc/BRIEF.md
# Recirculating Shuffle-Exchange Data Network

The block keeps one data word in each of 2^N cells. Each cell is numbered by an N-bit index. On every clock edge where a step is requested, every word moves at once along one of two fixed link patterns, and a single mode bit picks the pattern.

In shuffle mode each word goes from cell i to the cell whose index is i rotated left by one bit. The old top bit of the index becomes the new bottom bit. In exchange mode the two cells of each pair whose indices differ only in bit 0 trade their words.

A parallel load fills all cells in one cycle. The current contents are always visible on a parallel read-out bus. A chain of mode bits applied over successive steps carries any word to any cell.

Top module: `sx_net`

## Requirements
- R1: A synchronous active-high `rst` clears every cell to zero, and `cells_out` reads all zero on the cycle after the reset edge.
- R2: With `load` high on a rising edge, cell k takes `load_data[k*W +: W]` for every k at once.
- R3: When `load` and `step_valid` are both high on the same edge, the load wins. The cells take `load_data` unpermuted, whatever `mode` is.
- R4: When neither `load` nor `step_valid` is high on an edge, every cell keeps its word.
- R5: A step with `mode` = 0 (shuffle) moves the word in cell i to cell rotl(i), the N-bit left rotation of i. Cells 0 and 2^N-1 therefore keep their words.
- R6: A step with `mode` = 1 (exchange) swaps the words of cells 2m and 2m+1 for every m, in the same edge.
- R7: N consecutive shuffle steps, with no exchange in between, return every word to the cell it started in.
- R8: `cells_out[k*W +: W]` is the content of cell k. It is taken straight from the cell registers, so it changes on the edge that updates the cell and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load strobe |
| load_data | input | 2^N*W | Words to load, cell k in bits [k*W +: W] |
| step_valid | input | 1 | Request one network step on this edge |
| mode | input | 1 | Step pattern: 0 = shuffle, 1 = exchange |
| cells_out | output | 2^N*W | Current cell contents in index order |

## Verification
The load strobe and a step request can land on the same edge. The bench provokes this by raising `load` together with `step_valid` in exchange mode, and separately in shuffle mode, with fresh load data that differs from the current contents. The result is judged correct only if the read-out on the next cycle equals the new load data in plain index order, with no swap or rotation applied. A random-looking table of mode bits drives a reference model of indices, so that every shuffle and exchange is compared against an independently predicted placement.

// File: rtl/sx_pkg.sv
package sx_pkg;
  typedef enum logic {
    SX_SHUFFLE  = 1'b0,
    SX_EXCHANGE = 1'b1
  } sx_mode_e;

  typedef enum logic [1:0] {
    SX_OP_HOLD = 2'd0,
    SX_OP_LOAD = 2'd1,
    SX_OP_STEP = 2'd2
  } sx_op_e;
endpackage

// File: rtl/sx_route.sv
module sx_route #(
  parameter int N = 3,
  parameter int W = 8,
  localparam int CELLS = 1 << N
) (
  input  logic [CELLS*W-1:0] cur,
  input  sx_pkg::sx_mode_e   mode,
  output logic [CELLS*W-1:0] nxt
);
  // Source of destination j under shuffle: the cell whose left rotation is j.
  function automatic int rot_right(input int j);
    return (j >> 1) | ((j & 1) << (N - 1));
  endfunction

  for (genvar j = 0; j < CELLS; j++) begin : g_dst
    localparam int SRC_SH = rot_right(j);
    localparam int SRC_EX = j ^ 1;
    assign nxt[j*W +: W] = (mode == sx_pkg::SX_EXCHANGE) ?
                           cur[SRC_EX*W +: W] : cur[SRC_SH*W +: W];
  end
endmodule

// File: rtl/sx_ctrl.sv
module sx_ctrl (
  input  logic            load,
  input  logic            step_valid,
  output sx_pkg::sx_op_e  op
);
  always_comb begin
    if (load)            op = sx_pkg::SX_OP_LOAD;
    else if (step_valid) op = sx_pkg::SX_OP_STEP;
    else                 op = sx_pkg::SX_OP_HOLD;
  end
endmodule

// File: rtl/sx_store.sv
module sx_store #(
  parameter int N = 3,
  parameter int W = 8,
  localparam int CELLS = 1 << N
) (
  input  logic               clk,
  input  logic               rst,
  input  sx_pkg::sx_op_e     op,
  input  logic [CELLS*W-1:0] load_data,
  input  logic [CELLS*W-1:0] routed,
  output logic [CELLS*W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (op)
        sx_pkg::SX_OP_LOAD: q <= load_data;
        sx_pkg::SX_OP_STEP: q <= routed;
        default:            q <= q;
      endcase
    end
  end

  // R4: no operation leaves every cell unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (op == sx_pkg::SX_OP_HOLD) |=> $stable(q));
endmodule

// File: rtl/sx_net.sv
module sx_net #(
  parameter int N = 3,
  parameter int W = 8,
  localparam int CELLS = 1 << N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CELLS*W-1:0] load_data,
  input  logic               step_valid,
  input  logic               mode,
  output logic [CELLS*W-1:0] cells_out
);
  sx_pkg::sx_op_e     op;
  sx_pkg::sx_mode_e   mode_e;
  logic [CELLS*W-1:0] routed;

  assign mode_e = sx_pkg::sx_mode_e'(mode);

  sx_ctrl u_ctrl (
    .load       (load),
    .step_valid (step_valid),
    .op         (op)
  );

  sx_route #(.N(N), .W(W)) u_route (
    .cur  (cells_out),
    .mode (mode_e),
    .nxt  (routed)
  );

  sx_store #(.N(N), .W(W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .load_data (load_data),
    .routed    (routed),
    .q         (cells_out)
  );

  // R1: reset empties every cell
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cells_out == '0));

  // R2, R3: a load is taken verbatim, even with a step requested
  a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (cells_out == $past(load_data)));

  // R6: exchange swaps cells 0 and 1
  a_r6_exchange_pair: assert property (@(posedge clk) disable iff (rst)
    (step_valid && mode && !load) |=>
      (cells_out[0 +: W] == $past(cells_out[W +: W])) &&
      (cells_out[W +: W] == $past(cells_out[0 +: W])));

  // R5: shuffle fixes the all-zero and all-one indices
  a_r5_shuffle_ends: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !mode && !load) |=>
      (cells_out[0 +: W] == $past(cells_out[0 +: W])) &&
      (cells_out[(CELLS-1)*W +: W] == $past(cells_out[(CELLS-1)*W +: W])));
endmodule

// File: tb/sx_net_tb.sv
module sx_net_tb;
  localparam int N = 3;
  localparam int W = 8;
  localparam int CELLS = 1 << N;
  localparam int STEPS = 16;
  // step mode per table row, row 0 first: 0 = shuffle, 1 = exchange
  localparam logic [0:STEPS-1] MODE_TAB = 16'b0110_0010_1101_0001;

  logic clk = 1'b0;
  logic rst, load, step_valid, mode;
  logic [CELLS*W-1:0] load_data, cells_out;

  int n_chk = 0;
  int n_fail = 0;
  int where_is [CELLS]; // origin index held by each cell
  logic [CELLS*W-1:0] base, exp_v;
  bit done = 0;

  always #2 clk = ~clk;

  sx_net #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .load(load), .load_data(load_data),
    .step_valid(step_valid), .mode(mode), .cells_out(cells_out)
  );

  function automatic int rotl(input int i);
    return ((i << 1) & (CELLS - 1)) | (i >> (N - 1));
  endfunction

  function automatic logic [CELLS*W-1:0] pattern(input int seed);
    logic [CELLS*W-1:0] v;
    for (int k = 0; k < CELLS; k++) v[k*W +: W] = W'(seed + 7 * k);
    return v;
  endfunction

  task automatic check(input string req, input logic [CELLS*W-1:0] e);
    n_chk++;
    if (cells_out !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, cells_out, e);
    end
  endtask

  // apply one edge with the given controls, sample at the following negedge
  task automatic cycle(input logic ld, input logic st, input logic md);
    load = ld; step_valid = st; mode = md;
    @(posedge clk);
    @(negedge clk);
    load = 0; step_valid = 0;
  endtask

  task automatic model_step(input logic md);
    int nw [CELLS];
    for (int c = 0; c < CELLS; c++) begin
      if (md) nw[c ^ 1] = where_is[c];
      else    nw[rotl(c)] = where_is[c];
    end
    for (int c = 0; c < CELLS; c++) where_is[c] = nw[c];
  endtask

  function automatic logic [CELLS*W-1:0] model_view();
    logic [CELLS*W-1:0] v;
    for (int c = 0; c < CELLS; c++) v[c*W +: W] = base[where_is[c]*W +: W];
    return v;
  endfunction

  initial begin
    rst = 1; load = 0; step_valid = 0; mode = 0; load_data = '0;
    @(negedge clk);
    cycle(0, 0, 0);
    check("R1 reset state", '0);
    rst = 0;

    base = pattern(8'h11);
    load_data = base;
    cycle(1, 0, 0);
    check("R2 parallel load", base);
    for (int c = 0; c < CELLS; c++) where_is[c] = c;

    for (int s = 0; s < STEPS; s++) begin
      cycle(0, 1, MODE_TAB[s]);
      model_step(MODE_TAB[s]);
      check(MODE_TAB[s] ? "R6 exchange step (R8)" : "R5 shuffle step (R8)",
            model_view());
    end

    exp_v = model_view();
    cycle(0, 0, 1);
    cycle(0, 0, 0);
    check("R4 idle hold", exp_v);

    base = pattern(8'h50);
    load_data = base;
    cycle(1, 1, 1);
    check("R3 load beats exchange", base);
    load_data = pattern(8'h90);
    cycle(1, 1, 0);
    check("R3 load beats shuffle", pattern(8'h90));

    base = pattern(8'h33);
    load_data = base;
    cycle(1, 0, 0);
    for (int s = 0; s < N; s++) begin
      cycle(0, 1, 0);
      if (s == 0) begin
        for (int c = 0; c < CELLS; c++) exp_v[rotl(c)*W +: W] = base[c*W +: W];
        check("R5 single shuffle", exp_v);
      end
    end
    check("R7 N shuffles restore", base);

    cycle(0, 1, 1);
    rst = 1;
    cycle(0, 1, 1);
    check("R1 reset beats step", '0);
    rst = 0;
    cycle(0, 1, 0);
    check("R1 empty after reset", '0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule